// File: doc/BRIEF.md
# Register Write-Hazard Scoreboard

This block keeps one flag per architectural register that says a write to that register is still outstanding. An issuing instruction that names a destination raises its flag. The flag drops again when a register-file write port is granted for that register, or when the function unit that owns the write finishes without producing data. Alongside the flag array, the block answers hazard queries for the incoming instruction. Read-after-write queries compare source registers with the live flags. Write-after-write queries compare the destination register with a copy of the flags delayed by one cycle.

The raise is applied one cycle after issue. An instruction that reads and writes the same register therefore never sees a dependency on itself. Register selectors are either binary indices or one-hot/multi-hot masks, chosen at build time. All pins are plain level control and status. No data moves through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `hazard_scoreboard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every pending flag is zero and every hazard output is low.
- R2: A destination issued in cycle t (any unit's issue bit high, iss_wr high) shows in pend_o from cycle t+2. In cycle t+1 it is not yet visible, so neither pend_o nor a read query sees it.
- R3: A write-port grant for register k in cycle t clears pend_o bit k from cycle t+1, unless a raise for k takes effect in that same cycle.
- R4: When a unit pulses done while its captured write flag is set and its wrok input is low, the flag of its captured destination is cleared on the next cycle. When wrok is high, the done pulse clears nothing.
- R5: A unit's captured write flag is taken at its issue and dropped in any cycle in which the unit is not busy. A later done pulse from that unit then has no effect.
- R6: When a read port is enabled and not busy, rd_haz for that port is high exactly when its source mask shares a bit with pend_o in the same cycle.
- R7: While a read port is busy, its hazard is evaluated only if it was high in the previous cycle. Once it reads low while busy, it stays low even if the register becomes pending again.
- R8: When ww_en is high, ww_haz is high exactly when the destination mask shares a bit with pend_o as it stood one cycle earlier.
- R9: In binary mode (UNARY=0) a selector value v selects register v, i.e. mask 1<<v. In unary mode (UNARY=1) the selector is used as a mask directly, and more than one bit may be set.
- R10: Raise and clear masks are each OR-reduced over all of their sources. When both hit the same bit in one cycle, the bit ends up set.
- R11: any_haz is high exactly when some rd_haz bit or ww_haz is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fu_issue | input | NFU | Per-unit issue strobe |
| fu_busy | input | NFU | Per-unit busy level |
| fu_done | input | NFU | Per-unit completion pulse |
| fu_wrok | input | NFU | Per-unit result-valid flag at completion |
| iss_wr | input | 1 | Issuing instruction writes a register |
| iss_dst | input | SELW | Destination selector of the issuing instruction |
| wp_gnt | input | NWP | Write-port grant per port |
| wp_dst | input | NWP*SELW | Granted register selector per port, port 0 in the low bits |
| rd_en | input | NRP | Read-query enable per port |
| rd_busy | input | NRP | Querying unit already busy, per port |
| rd_src | input | NRP*SELW | Source selector per read port, port 0 in the low bits |
| ww_en | input | 1 | Write-after-write query enable |
| ww_dst | input | SELW | Destination selector from the decoder |
| rd_haz | output | NRP | Read-after-write hazard per port |
| ww_haz | output | 1 | Write-after-write hazard |
| any_haz | output | 1 | OR of all hazard flags |
| pend_o | output | NREG | Pending-write flags |

SELW is NREG when UNARY=1, otherwise clog2(NREG).

## Verification
The raise path and the clear path can land on the same register in the same cycle. This happens when a grant for a register arrives exactly one cycle after that register was issued as a destination, so the delayed raise and the clear meet. The bench provokes it in a directed case and very often in the random phase, which biases destinations and grants onto four registers. The result is judged from pend_o in the next cycle, where the bit must be set. A done-without-write notification that coincides with a grant is also covered, and must leave both bits cleared.

// File: rtl/hz_pkg.sv
package hz_pkg;
  function automatic int sel_width(input int nreg, input int unary);
    return (unary != 0) ? nreg : ((nreg > 1) ? $clog2(nreg) : 1);
  endfunction
endpackage

// File: rtl/hz_sel2mask.sv
module hz_sel2mask #(
  parameter int NREG  = 32,
  parameter int UNARY = 0,
  parameter int SELW  = hz_pkg::sel_width(NREG, UNARY)
) (
  input  logic [SELW-1:0] sel,
  input  logic            en,
  output logic [NREG-1:0] mask
);
  generate
    if (UNARY != 0) begin : g_unary
      always_comb mask = en ? NREG'(sel) : '0;
    end else begin : g_binary
      always_comb mask = en ? (NREG'(1) << sel) : '0;
    end
  endgenerate
endmodule

// File: rtl/hz_fu_track.sv
module hz_fu_track #(
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic            busy,
  input  logic            done,
  input  logic            wrok,
  input  logic            iss_wr,
  input  logic [NREG-1:0] iss_mask,
  output logic [NREG-1:0] clr_mask
);
  logic            wf_q;
  logic [NREG-1:0] dst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wf_q  <= 1'b0;
      dst_q <= '0;
    end else begin
      if (!busy) wf_q <= 1'b0;
      if (issue) begin
        wf_q  <= iss_wr;
        dst_q <= iss_mask;
      end
    end
  end

  always_comb clr_mask = (done && wf_q && !wrok) ? dst_q : '0;
endmodule

// File: rtl/hz_read_check.sv
module hz_read_check #(
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] pend,
  input  logic            en,
  input  logic            busy,
  input  logic [NREG-1:0] src_mask,
  output logic            haz
);
  logic            haz_q;
  logic [NREG-1:0] chk;

  always_comb begin
    chk = en ? src_mask : '0;
    if (busy && !haz_q) chk = '0;
    haz = |(pend & chk);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) haz_q <= 1'b0;
    else        haz_q <= haz;
  end
endmodule

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard #(
  parameter int NREG  = 32,
  parameter int UNARY = 0,
  parameter int NFU   = 4,
  parameter int NWP   = 2,
  parameter int NRP   = 3,
  localparam int SELW = hz_pkg::sel_width(NREG, UNARY)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NFU-1:0]      fu_issue,
  input  logic [NFU-1:0]      fu_busy,
  input  logic [NFU-1:0]      fu_done,
  input  logic [NFU-1:0]      fu_wrok,
  input  logic                iss_wr,
  input  logic [SELW-1:0]     iss_dst,
  input  logic [NWP-1:0]      wp_gnt,
  input  logic [NWP*SELW-1:0] wp_dst,
  input  logic [NRP-1:0]      rd_en,
  input  logic [NRP-1:0]      rd_busy,
  input  logic [NRP*SELW-1:0] rd_src,
  input  logic                ww_en,
  input  logic [SELW-1:0]     ww_dst,
  output logic [NRP-1:0]      rd_haz,
  output logic                ww_haz,
  output logic                any_haz,
  output logic [NREG-1:0]     pend_o
);
  logic [NREG-1:0] pend_q, pend_d1_q, set_q;
  logic [NREG-1:0] iss_mask, ww_mask, clr_all;
  logic [NREG-1:0] wp_mask [NWP];
  logic [NREG-1:0] fu_clr  [NFU];
  logic [NREG-1:0] rd_mask [NRP];
  logic            iss_fire;

  assign iss_fire = (|fu_issue) && iss_wr;

  hz_sel2mask #(.NREG(NREG), .UNARY(UNARY)) u_iss_dec (
    .sel(iss_dst), .en(1'b1), .mask(iss_mask));

  hz_sel2mask #(.NREG(NREG), .UNARY(UNARY)) u_ww_dec (
    .sel(ww_dst), .en(ww_en), .mask(ww_mask));

  genvar gi;
  generate
    for (gi = 0; gi < NWP; gi++) begin : g_wp
      hz_sel2mask #(.NREG(NREG), .UNARY(UNARY)) u_dec (
        .sel(wp_dst[gi*SELW +: SELW]), .en(wp_gnt[gi]), .mask(wp_mask[gi]));
    end
    for (gi = 0; gi < NFU; gi++) begin : g_fu
      hz_fu_track #(.NREG(NREG)) u_trk (
        .clk(clk), .rst_n(rst_n), .issue(fu_issue[gi]), .busy(fu_busy[gi]),
        .done(fu_done[gi]), .wrok(fu_wrok[gi]), .iss_wr(iss_wr),
        .iss_mask(iss_mask), .clr_mask(fu_clr[gi]));
    end
    for (gi = 0; gi < NRP; gi++) begin : g_rd
      hz_sel2mask #(.NREG(NREG), .UNARY(UNARY)) u_dec (
        .sel(rd_src[gi*SELW +: SELW]), .en(1'b1), .mask(rd_mask[gi]));
      hz_read_check #(.NREG(NREG)) u_chk (
        .clk(clk), .rst_n(rst_n), .pend(pend_q), .en(rd_en[gi]),
        .busy(rd_busy[gi]), .src_mask(rd_mask[gi]), .haz(rd_haz[gi]));
    end
  endgenerate

  // OR-reduce every clear source
  always_comb begin
    clr_all = '0;
    for (int i = 0; i < NWP; i++) clr_all |= wp_mask[i];
    for (int i = 0; i < NFU; i++) clr_all |= fu_clr[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_q     <= '0;
      pend_q    <= '0;
      pend_d1_q <= '0;
    end else begin
      set_q     <= iss_fire ? iss_mask : '0;
      pend_q    <= (pend_q & ~clr_all) | set_q;
      pend_d1_q <= pend_q;
    end
  end

  assign ww_haz  = |(pend_d1_q & ww_mask);
  assign any_haz = (|rd_haz) | ww_haz;
  assign pend_o  = pend_q;
endmodule

// File: rtl/hz_sb_checker.sv
module hz_sb_checker #(
  parameter int NREG  = 32,
  parameter int UNARY = 0,
  parameter int NFU   = 4,
  parameter int NWP   = 2,
  parameter int NRP   = 3,
  localparam int SELW = hz_pkg::sel_width(NREG, UNARY)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NFU-1:0]      fu_issue,
  input logic                iss_wr,
  input logic [SELW-1:0]     iss_dst,
  input logic [NWP-1:0]      wp_gnt,
  input logic [NWP*SELW-1:0] wp_dst,
  input logic [NRP-1:0]      rd_en,
  input logic [NRP-1:0]      rd_busy,
  input logic [NRP*SELW-1:0] rd_src,
  input logic                ww_en,
  input logic [SELW-1:0]     ww_dst,
  input logic [NRP-1:0]      rd_haz,
  input logic                ww_haz,
  input logic                any_haz,
  input logic [NREG-1:0]     pend_o
);
  function automatic logic [NREG-1:0] m(input logic [SELW-1:0] s);
    if (UNARY != 0) return NREG'(s);
    return NREG'(1) << s;
  endfunction

  logic            fire;
  logic [NREG-1:0] im, gm0, rm0, wm;
  assign fire = (|fu_issue) && iss_wr;
  assign im   = m(iss_dst);
  assign gm0  = m(wp_dst[SELW-1:0]);
  assign rm0  = m(rd_src[SELW-1:0]);
  assign wm   = m(ww_dst);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (pend_o == '0));

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ##2 ((pend_o & $past(im, 2)) == $past(im, 2)));

  p_grant_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_gnt[0] && !$past(fire)) |=> ((pend_o & $past(gm0)) == '0));

  p_read_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en[0] && !rd_busy[0]) |-> (rd_haz[0] == (|(pend_o & rm0))));

  p_waw_delayed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ww_en |-> (ww_haz == (|($past(pend_o) & wm))));

  p_any_covers_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rd_haz) || ww_haz) |-> any_haz);
endmodule

bind hazard_scoreboard hz_sb_checker #(
  .NREG(NREG), .UNARY(UNARY), .NFU(NFU), .NWP(NWP), .NRP(NRP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fu_issue(fu_issue), .iss_wr(iss_wr),
  .iss_dst(iss_dst), .wp_gnt(wp_gnt), .wp_dst(wp_dst), .rd_en(rd_en),
  .rd_busy(rd_busy), .rd_src(rd_src), .ww_en(ww_en), .ww_dst(ww_dst),
  .rd_haz(rd_haz), .ww_haz(ww_haz), .any_haz(any_haz), .pend_o(pend_o)
);

// File: tb/sim_hazard_scoreboard.sv
`timescale 1ns/1ps
module sim_hazard_scoreboard;
  localparam int NR = 32, NF = 4, NW = 2, NP = 3, SW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NF-1:0] fu_issue, fu_busy, fu_done, fu_wrok;
  logic iss_wr, ww_en;
  logic [SW-1:0] iss_dst, ww_dst;
  logic [NW-1:0] wp_gnt;
  logic [NW*SW-1:0] wp_dst;
  logic [NP-1:0] rd_en, rd_busy, rd_haz;
  logic [NP*SW-1:0] rd_src;
  logic ww_haz, any_haz;
  logic [NR-1:0] pend_o;

  hazard_scoreboard #(.NREG(NR), .UNARY(0), .NFU(NF), .NWP(NW), .NRP(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .fu_issue(fu_issue), .fu_busy(fu_busy),
    .fu_done(fu_done), .fu_wrok(fu_wrok), .iss_wr(iss_wr), .iss_dst(iss_dst),
    .wp_gnt(wp_gnt), .wp_dst(wp_dst), .rd_en(rd_en), .rd_busy(rd_busy),
    .rd_src(rd_src), .ww_en(ww_en), .ww_dst(ww_dst), .rd_haz(rd_haz),
    .ww_haz(ww_haz), .any_haz(any_haz), .pend_o(pend_o));

  // unary-mode instance, 8 registers
  logic [0:0] v_issue, v_gnt, v_rden, v_rdhaz;
  logic [7:0] v_dst, v_wdst, v_src, v_pend;
  logic v_wwhaz, v_any;
  hazard_scoreboard #(.NREG(8), .UNARY(1), .NFU(1), .NWP(1), .NRP(1)) u1 (
    .clk(clk), .rst_n(rst_n), .fu_issue(v_issue), .fu_busy(1'b0),
    .fu_done(1'b0), .fu_wrok(1'b0), .iss_wr(1'b1), .iss_dst(v_dst),
    .wp_gnt(v_gnt), .wp_dst(v_wdst), .rd_en(v_rden), .rd_busy(1'b0),
    .rd_src(v_src), .ww_en(1'b0), .ww_dst(8'h00), .rd_haz(v_rdhaz),
    .ww_haz(v_wwhaz), .any_haz(v_any), .pend_o(v_pend));

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    fu_issue = '0; fu_done = '0; fu_wrok = '0; iss_wr = 0; iss_dst = '0;
    wp_gnt = '0; wp_dst = '0; ww_en = 0; ww_dst = '0;
    rd_en = '0; rd_busy = '0; rd_src = '0; fu_busy = '0;
    v_issue = '0; v_gnt = '0; v_rden = '0; v_dst = '0; v_wdst = '0; v_src = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  function automatic logic [NR-1:0] bm(input logic [SW-1:0] v);
    return NR'(1) << v;   // R9 binary selection
  endfunction

  function automatic logic [SW-1:0] pick_reg();
    return ($urandom % 2) ? SW'($urandom % 4) : SW'($urandom);
  endfunction

  // bench reference model
  logic [NR-1:0] m_pend, m_pendq, m_setq;

  initial begin
    #2_000_000ns;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    rst_n = 0;
    tick();
    // R1: state under reset
    chk("R1 pend in reset", 64'(pend_o), 0);
    chk("R1 any_haz in reset", 64'(any_haz), 0);
    tick();
    rst_n = 1;
    chk("R1 pend after reset", 64'(pend_o), 0);

    // ---------------- random phase: R2 R3 R6 R8 R9 R10 R11 --------------
    m_pend = '0; m_pendq = '0; m_setq = '0;
    for (int c = 0; c < 600; c++) begin
      logic [NR-1:0] clr, rm;
      logic          exp_any, rh;
      fu_issue = ($urandom % 2) ? NF'(1 << ($urandom % NF)) : '0;
      iss_wr = $urandom % 4 != 0;
      iss_dst = pick_reg();
      wp_gnt = NW'($urandom % 4);
      wp_dst = {pick_reg(), pick_reg()};
      rd_en = NP'($urandom);
      rd_src = {pick_reg(), pick_reg(), pick_reg()};
      ww_en = $urandom % 2;
      ww_dst = pick_reg();
      #1;
      chk("R2/R3/R10 pend", 64'(pend_o), 64'(m_pend));
      exp_any = 0;
      for (int p = 0; p < NP; p++) begin
        rm = bm(rd_src[p*SW +: SW]);
        rh = rd_en[p] && ((m_pend & rm) != 0);
        exp_any |= rh;
        chk("R6 read hazard", 64'(rd_haz[p]), 64'(rh));
      end
      rh = ww_en && ((m_pendq & bm(ww_dst)) != 0);
      exp_any |= rh;
      chk("R8 waw hazard", 64'(ww_haz), 64'(rh));
      chk("R11 any_haz", 64'(any_haz), 64'(exp_any));
      clr = '0;
      for (int w = 0; w < NW; w++) if (wp_gnt[w]) clr |= bm(wp_dst[w*SW +: SW]);
      m_pendq = m_pend;
      m_pend = (m_pend & ~clr) | m_setq;
      m_setq = ((|fu_issue) && iss_wr) ? bm(iss_dst) : '0;
      tick();
    end

    // ---------------- directed cases ----------------
    do_reset();
    // R2 / R8: issue r5, own read not hazarded next cycle
    fu_issue = 4'b0001; iss_wr = 1; iss_dst = 5;
    tick();
    idle();
    rd_en = 3'b001; rd_src = 15'd5; ww_en = 1; ww_dst = 5;
    #1;
    chk("R2 not visible t+1", 64'(pend_o[5]), 0);
    chk("R2 no self read hazard", 64'(rd_haz[0]), 0);
    tick();
    chk("R2 visible t+2", 64'(pend_o[5]), 1);
    chk("R6 read hazard r5", 64'(rd_haz[0]), 1);
    chk("R8 waw still low", 64'(ww_haz), 0);
    tick();
    chk("R8 waw high a cycle later", 64'(ww_haz), 1);
    // R3: grant on port1 clears r5
    idle();
    wp_gnt = 2'b10; wp_dst = {5'd5, 5'd0};
    tick();
    idle();
    chk("R3 grant clears", 64'(pend_o[5]), 0);

    // R10: raise and clear on r7 in same cycle
    fu_issue = 4'b0010; iss_wr = 1; iss_dst = 7;
    tick();
    idle();
    wp_gnt = 2'b01; wp_dst = {5'd0, 5'd7};
    tick();
    idle();
    chk("R10 set wins", 64'(pend_o[7]), 1);

    // R4: unit 2 finishes without data, r9
    fu_issue = 4'b0100; iss_wr = 1; iss_dst = 9;
    tick();
    idle(); fu_busy = 4'b0100;
    tick();
    chk("R4 r9 pending", 64'(pend_o[9]), 1);
    fu_done = 4'b0100; fu_wrok = 4'b0000;
    wp_gnt = 2'b01; wp_dst = {5'd0, 5'd7};   // coincident grant on r7
    tick();
    idle();
    chk("R4 done-no-data clears r9", 64'(pend_o[9]), 0);
    chk("R10 coincident grant clears r7", 64'(pend_o[7]), 0);
    // R4: with wrok high nothing is cleared
    fu_issue = 4'b0010; iss_wr = 1; iss_dst = 10;
    tick();
    idle(); fu_busy = 4'b0010;
    tick();
    fu_done = 4'b0010; fu_wrok = 4'b0010;
    tick();
    fu_done = '0; fu_wrok = '0; fu_busy = '0;
    chk("R4 wrok keeps r10", 64'(pend_o[10]), 1);

    // R5: unit 3 drops busy before done
    fu_issue = 4'b1000; iss_wr = 1; iss_dst = 11;
    tick();
    idle();
    tick();
    tick();
    fu_done = 4'b1000;
    tick();
    idle();
    chk("R5 stale done ignored", 64'(pend_o[11]), 1);

    // R7: read port 0 on r10 through busy period
    rd_en = 3'b001; rd_src = 15'd10;
    #1;
    chk("R7 hazard before busy", 64'(rd_haz[0]), 1);
    tick();
    rd_busy = 3'b001;
    #1;
    chk("R7 busy keeps hazard", 64'(rd_haz[0]), 1);
    wp_gnt = 2'b01; wp_dst = {5'd0, 5'd10};
    tick();
    wp_gnt = '0;
    chk("R7 cleared", 64'(rd_haz[0]), 0);
    fu_issue = 4'b0001; iss_wr = 1; iss_dst = 10;
    tick();
    fu_issue = '0; iss_wr = 0;
    tick();
    chk("R7 r10 pending again", 64'(pend_o[10]), 1);
    chk("R7 check stopped", 64'(rd_haz[0]), 0);
    idle();

    // R10 OR-reduction: two grants clear two registers at once
    wp_gnt = 2'b11; wp_dst = {5'd10, 5'd11};
    tick();
    idle();
    chk("R10 two grants", 64'(pend_o[11:10]), 0);

    // R9: unary instance, multi-hot selector
    v_issue = 1'b1; v_dst = 8'h24;
    tick();
    v_issue = 1'b0;
    tick();
    chk("R9 unary set", 64'(v_pend), 64'h24);
    v_rden = 1'b1; v_src = 8'h04;
    #1;
    chk("R9 unary read hazard", 64'(v_rdhaz), 1);
    v_gnt = 1'b1; v_wdst = 8'h20;
    tick();
    v_gnt = 1'b0;
    chk("R9 unary clear", 64'(v_pend), 64'h04);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule